// File: doc/BRIEF.md
# Strobed LED Matrix Scan Controller

This block refreshes a four-character dot-matrix LED module with five columns and seven rows per character. Inside the module each character has its own 7-bit serial-to-parallel row register. The registers are chained, and each register advances on the falling edge of a shared shift clock. All characters share the five column lines. The controller lights one column at a time. It first streams the row bits of all four characters for that column into the chain, 28 bits in all. It then drives that column's strobe for a fixed on-time. After that it moves to the next column, and after the fifth column it returns to the first.

A host writes the 7-bit row pattern of any character and column into a staging buffer. The staging buffer is copied to the displayed buffer only at the end of a complete frame, so the module never shows part of an old frame and part of a new one. A separate pulse-width output sets the brightness. It is driven from an 8-bit level and has a period much shorter than one column on-time.

`SCLK_HALF` sets the serial clock rate in system cycles. `ON_CYCLES` sets the strobe on-time. Both are chosen from the system clock frequency so that the serial clock stays at or below 3 MHz and each column slot (load time plus on-time) stays within 2 ms, which gives a refresh rate of at least 100 Hz.

Top module: `ledscan_ctrl`

## Requirements
- R1: During and right after synchronous reset, `col_en` is 0, `sclk` is 1, `sdata` is 0, `frame_done` is 0 and `bright_en` is 0.
- R2: `sdata` never changes in a cycle where `sclk` changes. Serial data therefore changes only while `sclk` is high and is stable at each falling edge.
- R3: Each column load gives exactly 28 falling edges of `sclk` before the strobe turns on. The bits go out character index 3 first, then 2, 1 and 0. Within a character, row bit 6 goes first and row bit 0 goes last. A stored 1 is sent as `sdata` = 1, which means a lit dot.
- R4: `col_en` has at most one bit set, and `sclk` never falls while any strobe is on.
- R5: Strobes follow the order `col_en` bit 0, 1, 2, 3, 4 and then wrap to bit 0. Each strobe stays on for exactly `ON_CYCLES` consecutive cycles and never moves straight from one column to another.
- R6: `frame_done` is a single-cycle pulse. It is high only during the last cycle of the `col_en` bit 4 strobe, and it occurs once in every frame.
- R7: The displayed pattern changes only at frame boundaries. Writes made up to and including the cycle of a `frame_done` pulse are shown from the next frame on. Later writes are not shown in any column of the frame that is in progress.
- R8: `bright_en` is high for exactly `brightness` cycles out of every 255 consecutive cycles once `brightness` has been held steady for two periods. A value of 0 keeps it low and 255 keeps it high.
- R9: A write with `wr_en` = 1 stores `wr_rows` for character `wr_char` (0 to 3) and column `wr_col` (0 to 4). Row bit r is dot row r+1, and column index k is strobe bit k. A write with `wr_col` of 5 to 7 changes nothing that is displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the staging buffer |
| wr_char | input | 2 | Character index of the write |
| wr_col | input | 3 | Column index of the write |
| wr_rows | input | 7 | Row pattern, 1 = lit |
| brightness | input | 8 | PWM level for `bright_en` |
| sdata | output | 1 | Serial row data to the display chain |
| sclk | output | 1 | Shift clock; the chain samples on its falling edge |
| col_en | output | 5 | Column strobes, one-hot or zero |
| bright_en | output | 1 | Pulse-width-modulated driver enable |
| frame_done | output | 1 | One-cycle pulse at the end of the column-4 strobe |

## Verification
The bench rebuilds every 28-bit column load from the values on `sdata` at each falling edge and compares it with a bench model of the displayed buffer. A reversed character or row order, a missing or extra shift edge, or data that changes on a clock edge therefore shows up as a wrong word or a count other than 28. Random writes land mid-frame and sometimes use column indexes 5 to 7. A design that copied the buffer early would show a torn frame, and one that decoded the out-of-range columns would show unexpected dots. Strobe lengths, column order and the position of `frame_done` are timed cycle by cycle, so an off-by-one on-time or a strobe that overlaps the shifting is caught. The brightness levels 0, 1, 128 and 255 and some random levels are measured over a full 255-cycle window, which exposes a PWM whose period or comparison is off by one.

// File: rtl/ledscan_pkg.sv
// Shared types for the LED matrix scan controller.
package ledscan_pkg;

    // Sequencer state: issue a load, wait for the load, hold a strobe.
    typedef enum logic [1:0] {
        ST_KICK = 2'd0,
        ST_LOAD = 2'd1,
        ST_ON   = 2'd2
    } scan_st_t;

endpackage

// File: rtl/ledscan_pwm.sv
// Brightness PWM generator.
// Counts 0 .. 2^W-2, so one period is 2^W-1 cycles. The output is high
// for `level` cycles of each period. The level is latched at the period
// wrap, so a change never produces a short or runt pulse.
// Assumes W >= 2.
module ledscan_pwm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic         pwm_out
);
    localparam logic [W-1:0] TOP = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] cnt_q;
    logic [W-1:0] lvl_q;

    // Period counter, level latch and registered compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lvl_q   <= '0;
            pwm_out <= 1'b0;
        end else begin
            cnt_q   <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
            if (cnt_q == TOP) lvl_q <= level;
            pwm_out <= (cnt_q < lvl_q);
        end
    end
endmodule

// File: rtl/ledscan_framebuf.sv
// Double-buffered column pattern store.
// The host writes into a staging copy. On `swap`, the displayed copy takes
// the staging contents, including a write made in the same cycle. The read
// port gives one column of every character, character c at bits
// [c*N_ROW +: N_ROW]. Writes to column indexes >= N_COL match no cell.
// Assumes N_CHAR >= 2 and N_COL >= 2.
module ledscan_framebuf #(
    parameter int N_CHAR = 4,
    parameter int N_COL  = 5,
    parameter int N_ROW  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_CHAR)-1:0]  wr_char,
    input  logic [$clog2(N_COL)-1:0]   wr_col,
    input  logic [N_ROW-1:0]           wr_rows,
    input  logic                       swap,
    input  logic [$clog2(N_COL)-1:0]   rd_col,
    output logic [N_CHAR*N_ROW-1:0]    rd_data
);
    localparam int CW    = $clog2(N_CHAR);
    localparam int KW    = $clog2(N_COL);
    localparam int CELLS = N_CHAR * N_COL;

    logic [CELLS*N_ROW-1:0] live_flat;

    for (genvar c = 0; c < N_CHAR; c++) begin : g_char
        for (genvar k = 0; k < N_COL; k++) begin : g_col
            logic             hit;
            logic [N_ROW-1:0] stage_q, live_q, nx;

            assign hit = wr_en && (wr_char == CW'(c)) && (wr_col == KW'(k));
            assign nx  = hit ? wr_rows : stage_q;

            // Staging cell follows host writes; display cell copies on swap.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                    live_q  <= '0;
                end else begin
                    stage_q <= nx;
                    if (swap) live_q <= nx;
                end
            end

            assign live_flat[(c*N_COL+k)*N_ROW +: N_ROW] = live_q;
        end
    end

    // Column read mux across all characters.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < N_CHAR; c++) begin
            rd_data[c*N_ROW +: N_ROW] = live_flat[(c*N_COL + int'(rd_col))*N_ROW +: N_ROW];
        end
    end
endmodule

// File: rtl/ledscan_shifter.sv
// Serializer for one column load onto a falling-edge-clocked chain.
// One bit takes 2*HALF cycles: sclk is high for HALF cycles, then low for
// HALF cycles. sdata is updated one cycle after sclk rises, which keeps it
// clear of both clock edges. word[NBITS-1] goes out first. `done` is high
// in the last cycle of the load. `word` must stay stable while busy.
// Assumes HALF >= 2 and NBITS >= 2.
module ledscan_shifter #(
    parameter int NBITS = 28,
    parameter int HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] word,
    output logic             done,
    output logic             sclk,
    output logic             sdata
);
    localparam int PW = $clog2(2*HALF);
    localparam int KW = $clog2(NBITS);
    localparam logic [PW-1:0] P_LAST = PW'(2*HALF-1);
    localparam logic [PW-1:0] P_FALL = PW'(HALF);
    localparam logic [PW-1:0] P_DATA = PW'(1);
    localparam logic [KW-1:0] K_LAST = KW'(NBITS-1);

    logic          active_q;
    logic [PW-1:0] p_q;
    logic [KW-1:0] k_q;

    assign done = active_q && (p_q == P_LAST) && (k_q == K_LAST);

    // Bit-phase and bit-index counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            p_q      <= '0;
            k_q      <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                p_q      <= '0;
                k_q      <= '0;
            end
        end else if (p_q == P_LAST) begin
            p_q <= '0;
            if (k_q == K_LAST) active_q <= 1'b0;
            else               k_q      <= k_q + 1'b1;
        end else begin
            p_q <= p_q + 1'b1;
        end
    end

    // Registered pin drivers: clock level and data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk  <= 1'b1;
            sdata <= 1'b0;
        end else begin
            sclk <= !(active_q && (p_q >= P_FALL));
            if (active_q && (p_q == P_DATA)) sdata <= word[K_LAST - k_q];
        end
    end
endmodule

// File: rtl/ledscan_ctrl.sv
// LED matrix scan controller, top level.
// For each column in turn it loads N_CHAR*N_ROW row bits through the
// shifter, then holds that column's strobe for ON_CYCLES cycles. After the
// last column it pulses frame_done, and that pulse swaps in the staged
// pattern. Strobes are registered and low for the whole load.
// Assumes SCLK_HALF >= 2 and ON_CYCLES >= 2. Choose both from the system
// clock so that the shift rate stays at or below 3 MHz and each column slot
// stays within 2 ms.
module ledscan_ctrl
    import ledscan_pkg::*;
#(
    parameter int N_CHAR    = 4,
    parameter int N_COL     = 5,
    parameter int N_ROW     = 7,
    parameter int SCLK_HALF = 2,
    parameter int ON_CYCLES = 2048,
    parameter int PWM_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_CHAR)-1:0] wr_char,
    input  logic [$clog2(N_COL)-1:0]  wr_col,
    input  logic [N_ROW-1:0]          wr_rows,
    input  logic [PWM_W-1:0]          brightness,
    output logic                      sdata,
    output logic                      sclk,
    output logic [N_COL-1:0]          col_en,
    output logic                      bright_en,
    output logic                      frame_done
);
    localparam int NBITS = N_CHAR * N_ROW;
    localparam int KW    = $clog2(N_COL);
    localparam int OW    = $clog2(ON_CYCLES);
    localparam logic [KW-1:0]    COL_LAST = KW'(N_COL-1);
    localparam logic [OW-1:0]    ON_LAST  = OW'(ON_CYCLES-1);
    localparam logic [N_COL-1:0] COL_ONE  = N_COL'(1);

    scan_st_t         state_q;
    logic [KW-1:0]    col_q;
    logic [OW-1:0]    on_q;
    logic [NBITS-1:0] word;
    logic             ld_done;
    logic             on_end;

    assign on_end = (state_q == ST_ON) && (on_q == ON_LAST);

    ledscan_framebuf #(.N_CHAR(N_CHAR), .N_COL(N_COL), .N_ROW(N_ROW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_char(wr_char), .wr_col(wr_col), .wr_rows(wr_rows),
        .swap(frame_done), .rd_col(col_q), .rd_data(word)
    );

    ledscan_shifter #(.NBITS(NBITS), .HALF(SCLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(state_q == ST_KICK), .word(word), .done(ld_done),
        .sclk(sclk), .sdata(sdata)
    );

    ledscan_pwm #(.W(PWM_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .level(brightness), .pwm_out(bright_en)
    );

    // Column sequencer: kick a load, wait for it, time the strobe, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_KICK;
            col_q   <= '0;
            on_q    <= '0;
        end else begin
            case (state_q)
                ST_KICK: state_q <= ST_LOAD;
                ST_LOAD: if (ld_done) begin
                    state_q <= ST_ON;
                    on_q    <= '0;
                end
                ST_ON: begin
                    on_q <= on_q + 1'b1;
                    if (on_end) begin
                        state_q <= ST_KICK;
                        col_q   <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
                    end
                end
                default: state_q <= ST_KICK;
            endcase
        end
    end

    // Registered strobe and frame-end pulse, aligned with the shifter pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_en     <= '0;
            frame_done <= 1'b0;
        end else begin
            col_en     <= (state_q == ST_ON) ? (COL_ONE << col_q) : '0;
            frame_done <= on_end && (col_q == COL_LAST);
        end
    end
endmodule

// File: rtl/ledscan_ctrl_chk.sv
// Port-level protocol checker for ledscan_ctrl, attached by bind.
module ledscan_ctrl_chk #(
    parameter int N_COL = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             sdata,
    input logic [N_COL-1:0] col_en,
    input logic             frame_done
);
    // R2: data is held across both shift clock edges.
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> (sdata == $past(sdata)));

    // R4: at most one strobe at a time.
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en));

    // R4: no shifting while a column is lit.
    p_no_shift_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_en != '0) |-> sclk);

    // R5: a strobe never moves directly to another column.
    p_no_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(col_en) != '0) && (col_en != '0)) |-> (col_en == $past(col_en)));

    // R6: frame_done lasts one cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R6: frame_done falls inside the last column's strobe.
    p_done_last_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> col_en[N_COL-1]);
endmodule

bind ledscan_ctrl ledscan_ctrl_chk #(.N_COL(N_COL)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
    .col_en(col_en), .frame_done(frame_done)
);

// File: tb/sim_ledscan_ctrl.sv
module sim_ledscan_ctrl;
    localparam int CLK_P = 10;
    localparam int ON    = 2048;
    localparam int HALF  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_char = '0;
    logic [2:0] wr_col = '0;
    logic [6:0] wr_rows = '0;
    logic [7:0] brightness = '0;
    logic       sdata, sclk, bright_en, frame_done;
    logic [4:0] col_en;

    ledscan_ctrl #(.SCLK_HALF(HALF), .ON_CYCLES(ON)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_char(wr_char),
        .wr_col(wr_col), .wr_rows(wr_rows), .brightness(brightness),
        .sdata(sdata), .sclk(sclk), .col_en(col_en),
        .bright_en(bright_en), .frame_done(frame_done)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [6:0] stage_exp [4][5];
    logic [6:0] live_exp  [4][5];

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected column word: character 3 first, row bit 6 first (R3).
    function automatic logic [27:0] exp_word(int col);
        logic [27:0] w = '0;
        for (int c = 3; c >= 0; c--)
            for (int r = 6; r >= 0; r--)
                w = {w[26:0], live_exp[c][col][r]};
        return w;
    endfunction

    // Port monitor
    logic        prev_sclk = 1'b1, prev_sdata = 1'b0, prev_fd = 1'b0;
    logic [4:0]  prev_ce = '0;
    logic [27:0] shreg = '0;
    int nbits = 0, slen = 0, exp_col = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sclk !== prev_sclk)
                chk(sdata === prev_sdata, "R2 data moved on sclk edge", sdata, prev_sdata);
            if (prev_sclk && !sclk) begin
                if (col_en != 0) chk(0, "R4 shift while lit", col_en, 0);
                shreg = {shreg[26:0], sdata};
                nbits++;
            end
            if (prev_ce == 0 && col_en != 0) begin
                chk(nbits == 28, "R3 shift count", nbits, 28);
                chk(shreg == exp_word(exp_col), "R3 column word", shreg, exp_word(exp_col));
                chk(col_en == (5'b1 << exp_col), "R5 column order", col_en, 5'b1 << exp_col);
                nbits = 0;
                slen = 1;
            end else if (col_en != 0) begin
                if (col_en != prev_ce) chk(0, "R5 strobe jumped", col_en, prev_ce);
                slen++;
            end
            if (prev_ce != 0 && col_en == 0) begin
                chk(slen == ON, "R5 strobe length", slen, ON);
                if (exp_col == 4) chk(prev_fd, "R6 frame_done missing", prev_fd, 1);
                exp_col = (exp_col + 1) % 5;
            end
            if (frame_done) begin
                chk(col_en[4] && !prev_fd, "R6 frame_done placement", col_en, 5'b10000);
                live_exp = stage_exp;   // R7: swap at frame boundary only
            end
            prev_sclk  = sclk;
            prev_sdata = sdata;
            prev_ce    = col_en;
            prev_fd    = frame_done;
        end
    end

    // R9 write: columns 5..7 leave the model unchanged.
    task automatic wr(int c, int k, logic [6:0] rows);
        @(posedge clk); #(CLK_P/4);
        wr_en = 1'b1; wr_char = 2'(c); wr_col = 3'(k); wr_rows = rows;
        if (k < 5) stage_exp[c][k] = rows;
        @(posedge clk); #(CLK_P/4);
        wr_en = 1'b0;
    endtask

    task automatic wait_frames(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!frame_done) @(negedge clk);
        end
    endtask

    // R8 duty measurement over one full period.
    task automatic meas(logic [7:0] b);
        int cnt = 0;
        @(posedge clk); #(CLK_P/4);
        brightness = b;
        repeat (800) @(negedge clk);
        for (int i = 0; i < 255; i++) begin
            @(negedge clk);
            if (bright_en) cnt++;
        end
        chk(cnt == int'(b), "R8 pwm duty", cnt, b);
    endtask

    task automatic patterns();
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) wr(c, k, 7'h7F);
        wait_frames(2);
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) wr(c, k, (c == 3 && k == 0) ? 7'h40 : 7'h00);
        wr(0, 6, 7'h7F);                    // R9 ignored column index
        wait_frames(1);
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) wr(c, k, ((c + k) % 2) ? 7'h55 : 7'h2A);
        wait_frames(1);
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < 12; i++) begin
                repeat ($urandom_range(1500)) @(posedge clk);
                wr($urandom_range(3), $urandom_range(7), 7'($urandom));
            end
        end
        wait_frames(2);
    endtask

    task automatic levels();
        meas(8'd0);
        meas(8'd255);
        meas(8'd1);
        meas(8'd128);
        for (int i = 0; i < 3; i++) meas(8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) begin
                stage_exp[c][k] = '0;
                live_exp[c][k]  = '0;
            end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(col_en == 0, "R1 col_en reset", col_en, 0);
        chk(sclk == 1'b1, "R1 sclk reset", sclk, 1);
        chk(sdata == 1'b0, "R1 sdata reset", sdata, 0);
        chk(frame_done == 1'b0, "R1 frame_done reset", frame_done, 0);
        chk(bright_en == 1'b0, "R1 bright_en reset", bright_en, 0);
        @(posedge clk); #(CLK_P/4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_en == 0 && sclk == 1'b1, "R1 state after release", {col_en, sclk}, 1);
        fork
            patterns();
            levels();
        join
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule